// File: doc/BRIEF.md
# One-way UDP/IPv4 Ethernet frame transmitter

This block turns a payload byte stream into complete Ethernet II frames that carry one UDP datagram over IPv4. It is meant for a link where this station only sends and never listens. All addresses and both UDP ports come from static configuration inputs, so no address-resolution exchange is needed. A broadcast input sends the frame to the all-ones hardware address instead of the configured destination.

A frame starts when the block is idle and the payload source raises `pl_valid`. At that moment `pl_len` is sampled (lengths above 1472 are clamped to 1472). The block then emits the preamble, the Ethernet, IPv4 and UDP headers, the payload, zero padding when it is needed, and the 32-bit frame check sequence. Output is one byte per clock with `tx_en` high, toward a PHY-side serializer. The payload is pulled with `pl_ready` only while payload bytes are going out. A byte slot in which `pl_valid` is low is sent as 0x00 and still counts toward the length.

Top module: `udp_tx_framer`

## Requirements
- R1: Every frame begins with seven 0x55 bytes and then one 0xD5 byte. These are the first eight bytes with `tx_en` high.
- R2: The Ethernet header that follows has three parts, in this order. First comes the destination address, most significant byte first: `cfg_dst_mac`, or FF:FF:FF:FF:FF:FF when `cfg_bcast` is 1. Then comes `cfg_src_mac`, and then the type bytes 0x08, 0x00.
- R3: The 20-byte IPv4 header is sent in this byte order:
  - 0x45, 0x00, then the total length (28 plus the payload length, high byte first);
  - identification 0x0000, then flags/fragment 0x4000 (don't-fragment);
  - TTL 0x40, then protocol 0x11;
  - the header checksum;
  - `cfg_src_ip`, then `cfg_dst_ip`, each most significant byte first.

  The checksum is the complement of the ones'-complement sum of the header's 16-bit words, with the checksum field taken as zero during the sum.
- R4: The 8-byte UDP header carries four 16-bit fields, each high byte first: `cfg_src_port`, `cfg_dst_port`, the UDP length (8 plus the payload length), and a checksum of 0x0000.
- R5: The payload bytes follow the UDP header in the order they were accepted. `pl_ready` is high only in cycles where a payload byte is taken. Exactly as many handshakes occur as the (clamped) payload length.
- R6: When the payload is shorter than 18 bytes, zero bytes follow it. The frame is then exactly 64 bytes long from the destination address to the last check byte, which is 72 bytes with the preamble.
- R7: The last four bytes are a CRC-32 over every byte after the 0xD5 and before the check bytes. The CRC uses the reflected polynomial 0xEDB88320 and starts from all ones. The final value is inverted and sent least significant byte first. Running the same CRC over the data and the check bytes therefore leaves the register at 0xDEBB20E3.
- R8: A `pl_len` above 1472 is treated as 1472. The length fields are then 1500 (IPv4) and 1480 (UDP), and only 1472 bytes are taken.
- R9: Between the last byte of one frame and the first byte of the next, `tx_en` stays low for at least 12 cycles, even when a new payload is already waiting.
- R10: While reset is asserted, and after it until a payload is offered, `tx_en` and `pl_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_src_mac | input | 48 | This station's hardware address |
| cfg_dst_mac | input | 48 | Destination hardware address used when not broadcasting |
| cfg_bcast | input | 1 | 1 sends to the all-ones hardware address |
| cfg_src_ip | input | 32 | This station's IPv4 address |
| cfg_dst_ip | input | 32 | Destination IPv4 address |
| cfg_src_port | input | 16 | UDP source port |
| cfg_dst_port | input | 16 | UDP destination port |
| pl_valid | input | 1 | Payload offered; in idle, starts a frame |
| pl_ready | output | 1 | Payload byte taken at this clock edge |
| pl_data | input | 8 | Payload byte |
| pl_len | input | 11 | Payload length, sampled when a frame starts |
| tx_en | output | 1 | Frame byte valid on `tx_data` |
| tx_data | output | 8 | Frame byte toward the serializer |

## Verification
The bench sweeps payload lengths around the padding edge: 0, 5, 17, 18 and 19 bytes, plus a longer frame. An off-by-one in the pad count would show up as a 63- or 65-byte frame, or as a stray zero byte after an 18-byte payload. An oversized length of 1500 is offered to show the clamp. A design without the clamp would pull 1500 bytes and write 1528 into the IPv4 length. Alternating broadcast and unicast frames show whether the destination override reaches only the first six header bytes. The CRC is checked both against the bench's own value and through the fixed residue, which catches a wrong bit order or a missing final inversion. Frames are offered back to back so that too short an inter-frame gap shows up as fewer than 12 idle cycles.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_PAY,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } tx_state_t;

  // Ethernet (14) + IPv4 (20) + UDP (8) header bytes
  localparam int HDR_BYTES  = 42;
  localparam int IP_UDP_HDR = 28;
  localparam int UDP_HDR    = 8;

  // One byte of reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc32_step(input logic [31:0] c_in,
                                             input logic [7:0]  b);
    logic [31:0] c;
    c = c_in ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/udp_tx_crc32.sv
module udp_tx_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  import udp_tx_pkg::*;

  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init) begin
      crc_d = '1;
    end else if (en) begin
      crc_d = crc32_step(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (init || en) begin
      crc_q <= crc_d;
    end
  end

endmodule

// File: rtl/udp_tx_ipcsum.sv
module udp_tx_ipcsum #(
  parameter int LEN_W = 11
) (
  input  logic [LEN_W-1:0] pay_len,
  input  logic [31:0]      src_ip,
  input  logic [31:0]      dst_ip,
  output logic [15:0]      tot_len,
  output logic [15:0]      csum
);
  import udp_tx_pkg::*;

  localparam int NWORDS = 9;

  logic [15:0] words [NWORDS];
  logic [19:0] acc;
  logic [16:0] fold1;
  logic [16:0] fold2;

  assign tot_len = 16'(pay_len) + 16'(IP_UDP_HDR);

  always_comb begin
    words[0] = 16'h4500;
    words[1] = tot_len;
    words[2] = 16'h0000;
    words[3] = 16'h4000;
    words[4] = 16'h4011;
    words[5] = src_ip[31:16];
    words[6] = src_ip[15:0];
    words[7] = dst_ip[31:16];
    words[8] = dst_ip[15:0];
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NWORDS; i++) begin
      acc = acc + {4'h0, words[i]};
    end
    fold1 = {1'b0, acc[15:0]} + {13'h0, acc[19:16]};
    fold2 = {1'b0, fold1[15:0]} + {16'h0, fold1[16]};
    csum  = ~fold2[15:0];
  end

endmodule

// File: rtl/udp_tx_hdr.sv
module udp_tx_hdr #(
  parameter int LEN_W = 11
) (
  input  logic [47:0]      src_mac,
  input  logic [47:0]      dst_mac,
  input  logic             bcast,
  input  logic [31:0]      src_ip,
  input  logic [31:0]      dst_ip,
  input  logic [15:0]      src_port,
  input  logic [15:0]      dst_port,
  input  logic [LEN_W-1:0] pay_len,
  input  logic [15:0]      tot_len,
  input  logic [15:0]      csum,
  input  logic [5:0]       idx,
  output logic [7:0]       hdr_byte
);
  import udp_tx_pkg::*;

  localparam int VW = HDR_BYTES * 8;

  logic [47:0]   dst_eff;
  logic [15:0]   udp_len;
  logic [VW-1:0] hvec;
  logic [VW-1:0] hshift;

  assign dst_eff = bcast ? 48'hFFFF_FFFF_FFFF : dst_mac;
  assign udp_len = 16'(pay_len) + 16'(UDP_HDR);

  assign hvec = {dst_eff, src_mac, 16'h0800,
                 8'h45, 8'h00, tot_len, 16'h0000, 16'h4000,
                 8'd64, 8'd17, csum, src_ip, dst_ip,
                 src_port, dst_port, udp_len, 16'h0000};

  assign hshift   = hvec << {idx, 3'b000};
  assign hdr_byte = hshift[VW-1 -: 8];

endmodule

// File: rtl/udp_tx_framer.sv
module udp_tx_framer #(
  parameter int MAX_PAYLOAD = 1472,
  parameter int LEN_W       = 11,
  parameter int PRE_BYTES   = 7,
  parameter int GAP_BYTES   = 12,
  parameter int MIN_FRAME   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      cfg_src_mac,
  input  logic [47:0]      cfg_dst_mac,
  input  logic             cfg_bcast,
  input  logic [31:0]      cfg_src_ip,
  input  logic [31:0]      cfg_dst_ip,
  input  logic [15:0]      cfg_src_port,
  input  logic [15:0]      cfg_dst_port,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic [7:0]       pl_data,
  input  logic [LEN_W-1:0] pl_len,
  output logic             tx_en,
  output logic [7:0]       tx_data
);
  import udp_tx_pkg::*;

  localparam int CNT_W    = LEN_W;
  localparam int MIN_DATA = MIN_FRAME - 4 - HDR_BYTES;   // smallest unpadded payload
  localparam int FULL_MIN = MIN_FRAME + PRE_BYTES + 1;   // on-wire bytes incl. preamble
  localparam int FB_W     = LEN_W + 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  tx_state_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [7:0]       byte_d, data_q;
  logic             en_d, en_q;
  logic             crc_init, crc_en;
  logic [31:0]      crc_q;
  logic [15:0]      tot_len, csum;
  logic [7:0]       hdr_byte;
  logic [LEN_W-1:0] pad_len;
  logic             has_pad;

  assign pad_len = (len_q < LEN_W'(MIN_DATA)) ? (LEN_W'(MIN_DATA) - len_q) : '0;
  assign has_pad = (pad_len != '0);

  udp_tx_ipcsum #(.LEN_W(LEN_W)) u_csum (
    .pay_len (len_q),
    .src_ip  (cfg_src_ip),
    .dst_ip  (cfg_dst_ip),
    .tot_len (tot_len),
    .csum    (csum)
  );

  udp_tx_hdr #(.LEN_W(LEN_W)) u_hdr (
    .src_mac  (cfg_src_mac),
    .dst_mac  (cfg_dst_mac),
    .bcast    (cfg_bcast),
    .src_ip   (cfg_src_ip),
    .dst_ip   (cfg_dst_ip),
    .src_port (cfg_src_port),
    .dst_port (cfg_dst_port),
    .pay_len  (len_q),
    .tot_len  (tot_len),
    .csum     (csum),
    .idx      (cnt_q[5:0]),
    .hdr_byte (hdr_byte)
  );

  udp_tx_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .init  (crc_init),
    .en    (crc_en),
    .din   (byte_d),
    .crc_q (crc_q)
  );

  // next-state and output byte
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    byte_d   = 8'h00;
    en_d     = 1'b0;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    pl_ready = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pl_valid) begin
          len_d = (pl_len > LEN_W'(MAX_PAYLOAD)) ? LEN_W'(MAX_PAYLOAD) : pl_len;
          cnt_d = '0;
          st_d  = ST_PRE;
        end
      end
      ST_PRE: begin
        en_d     = 1'b1;
        crc_init = 1'b1;
        byte_d   = (cnt_q == CNT_W'(PRE_BYTES)) ? 8'hD5 : 8'h55;
        if (cnt_q == CNT_W'(PRE_BYTES)) begin
          cnt_d = '0;
          st_d  = ST_HDR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HDR: begin
        en_d   = 1'b1;
        crc_en = 1'b1;
        byte_d = hdr_byte;
        if (cnt_q == CNT_W'(HDR_BYTES - 1)) begin
          cnt_d = '0;
          if (len_q != '0) st_d = ST_PAY;
          else             st_d = has_pad ? ST_PAD : ST_FCS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAY: begin
        en_d     = 1'b1;
        crc_en   = 1'b1;
        pl_ready = 1'b1;
        byte_d   = pl_valid ? pl_data : 8'h00;
        if (cnt_q == len_q - 1'b1) begin
          cnt_d = '0;
          st_d  = has_pad ? ST_PAD : ST_FCS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAD: begin
        en_d   = 1'b1;
        crc_en = 1'b1;
        if (cnt_q == pad_len - 1'b1) begin
          cnt_d = '0;
          st_d  = ST_FCS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FCS: begin
        en_d   = 1'b1;
        byte_d = ~crc_q[{cnt_q[1:0], 3'b000} +: 8];
        if (cnt_q == CNT_W'(3)) begin
          cnt_d = '0;
          st_d  = ST_GAP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == CNT_W'(GAP_BYTES - 1)) begin
          cnt_d = '0;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      en_q   <= 1'b0;
      data_q <= 8'h00;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      en_q   <= en_d;
      data_q <= byte_d;
      if (st_q == ST_IDLE) len_q <= len_d;
    end
  end

  assign tx_en   = en_q;
  assign tx_data = data_q;

  // ---------------- assertions ----------------
  logic [4:0]      idle_run;
  logic [FB_W-1:0] fb_cnt;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      idle_run <= 5'(GAP_BYTES);
      fb_cnt   <= '0;
    end else begin
      if (en_q) idle_run <= '0;
      else if (idle_run < 5'(GAP_BYTES)) idle_run <= idle_run + 1'b1;
      if (en_q) fb_cnt <= fb_cnt + 1'b1;
      else      fb_cnt <= '0;
    end
  end

  assert_preamble_start_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(en_q) |-> (data_q == 8'h55));

  assert_ready_only_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    pl_ready |=> en_q);

  assert_min_frame_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(en_q) |-> (fb_cnt >= FB_W'(FULL_MIN)));

  assert_len_clamped_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q != ST_IDLE) |-> (len_q <= LEN_W'(MAX_PAYLOAD)));

  assert_gap_kept_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(en_q) |-> (idle_run >= 5'(GAP_BYTES)));

endmodule

// File: tb/udp_tx_framer_tb.sv
module udp_tx_framer_tb;

  localparam logic [47:0] SMAC  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] DMAC  = 48'h00_AA_BB_CC_DD_EE;
  localparam logic [31:0] SIP   = 32'hC0A8_0132;
  localparam logic [31:0] DIP   = 32'hC0A8_0101;
  localparam logic [15:0] SPORT = 16'h1234;
  localparam logic [15:0] DPORT = 16'h5678;
  localparam int          LIMIT = 150000;

  // {len[10:0], bcast, seed[7:0]}
  localparam int NVEC = 6;
  localparam logic [19:0] VEC [0:NVEC-1] = '{
    {11'd0,   1'b0, 8'h10},
    {11'd5,   1'b1, 8'h20},
    {11'd17,  1'b0, 8'h30},
    {11'd18,  1'b1, 8'h40},
    {11'd19,  1'b0, 8'h50},
    {11'd200, 1'b0, 8'h60}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_bcast;
  logic        pl_valid, pl_ready;
  logic [7:0]  pl_data;
  logic [10:0] pl_len;
  logic        tx_en;
  logic [7:0]  tx_data;

  always #10 clk = ~clk;

  udp_tx_framer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_src_mac  (SMAC),
    .cfg_dst_mac  (DMAC),
    .cfg_bcast    (cfg_bcast),
    .cfg_src_ip   (SIP),
    .cfg_dst_ip   (DIP),
    .cfg_src_port (SPORT),
    .cfg_dst_port (DPORT),
    .pl_valid     (pl_valid),
    .pl_ready     (pl_ready),
    .pl_data      (pl_data),
    .pl_len       (pl_len),
    .tx_en        (tx_en),
    .tx_data      (tx_data)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit hung  = 0;

  // payload source
  logic       go  = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] seed = 8'h00;
  int         idx = 0;

  assign pl_valid = go;
  assign pl_data  = seed + 8'(idx);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) idx <= 0;
    else if (pl_valid && pl_ready) idx <= idx + 1;
  end

  // output monitor
  logic [7:0] cap [0:8191];
  int  ncap    = 0;
  int  frames  = 0;
  int  low_run = 0;
  int  min_gap = 1000000;
  bit  prev_en = 1'b0;

  always @(negedge clk) begin
    if (tx_en === 1'b1) begin
      if (ncap < 8192) cap[ncap] = tx_data;
      ncap = ncap + 1;
      if (!prev_en && frames > 0 && low_run < min_gap) min_gap = low_run;
      low_run = 0;
    end else begin
      low_run = low_run + 1;
      if (prev_en) frames = frames + 1;
    end
    prev_en = (tx_en === 1'b1);
  end

  // expected frame
  logic [7:0] e [0:1599];
  int en_n;

  task automatic put(input logic [7:0] b);
    e[en_n] = b;
    en_n = en_n + 1;
  endtask

  function automatic logic [31:0] crc_over(input int from, input int upto, input bit use_cap,
                                           input int base);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [7:0]  b;
    for (int k = from; k < upto; k++) begin
      b = use_cap ? cap[base + k] : e[k];
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ b[j]) c = {1'b0, c[31:1]} ^ 32'hEDB88320;
        else             c = {1'b0, c[31:1]};
      end
    end
    return c;
  endfunction

  task automatic build(input int plen, input bit bc, input logic [7:0] sd);
    logic [15:0] tl, ul, cs;
    logic [31:0] s;
    logic [31:0] c;
    logic [47:0] d;
    en_n = 0;
    tl = 16'(plen + 28);
    ul = 16'(plen + 8);
    s = 32'h4500 + tl + 32'h4000 + 32'h4011 + SIP[31:16] + SIP[15:0] + DIP[31:16] + DIP[15:0];
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    cs = ~s[15:0];
    for (int k = 0; k < 7; k++) put(8'h55);
    put(8'hD5);
    d = bc ? 48'hFFFF_FFFF_FFFF : DMAC;
    for (int k = 5; k >= 0; k--) put(d[k*8 +: 8]);
    for (int k = 5; k >= 0; k--) put(SMAC[k*8 +: 8]);
    put(8'h08); put(8'h00);
    put(8'h45); put(8'h00); put(tl[15:8]); put(tl[7:0]);
    put(8'h00); put(8'h00); put(8'h40); put(8'h00);
    put(8'h40); put(8'h11); put(cs[15:8]); put(cs[7:0]);
    for (int k = 3; k >= 0; k--) put(SIP[k*8 +: 8]);
    for (int k = 3; k >= 0; k--) put(DIP[k*8 +: 8]);
    put(SPORT[15:8]); put(SPORT[7:0]);
    put(DPORT[15:8]); put(DPORT[7:0]);
    put(ul[15:8]); put(ul[7:0]);
    put(8'h00); put(8'h00);
    for (int k = 0; k < plen; k++) put(8'(sd + 8'(k)));
    while (en_n - 8 < 60) put(8'h00);
    c = ~crc_over(8, en_n, 1'b0, 0);
    for (int k = 0; k < 4; k++) put(c[k*8 +: 8]);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_range(input int base, input int lo, input int hi, input string req,
                           input string what);
    int bad_at = -1;
    for (int k = lo; k < hi; k++) begin
      if (bad_at < 0 && cap[base + k] !== e[k]) bad_at = k;
    end
    if (bad_at < 0) check(1'b1, req, what, 0, 0);
    else check(1'b0, req, {what, " byte"}, int'(cap[base + bad_at]), int'(e[bad_at]));
  endtask

  task automatic run_frame(input int len, input bit bc, input logic [7:0] sd,
                           input string lreq);
    int base, f0, eff, got, plen;
    if (hung) return;
    @(negedge clk);
    cfg_bcast = bc;
    pl_len    = 11'(len);
    seed      = sd;
    clr       = 1'b1;
    @(negedge clk);
    clr  = 1'b0;
    base = ncap;
    f0   = frames;
    go   = 1'b1;
    while (frames == f0 && cyc < LIMIT) @(negedge clk);
    go = 1'b0;
    if (frames == f0) begin
      hung = 1;
      check(1'b0, "R5", "watchdog expired waiting for frame", frames, f0 + 1);
      return;
    end
    eff  = (len > 1472) ? 1472 : len;
    build(eff, bc, sd);
    got  = ncap - base;
    check(got == en_n, lreq, "frame length", got, en_n);
    check(idx == eff, "R5", "payload handshakes", idx, eff);
    if (got != en_n) return;
    plen = (eff < 18) ? 18 : eff;
    cmp_range(base, 0, 8, "R1", "preamble/SFD");
    cmp_range(base, 8, 22, "R2", "ethernet header");
    cmp_range(base, 22, 42, "R3", "ipv4 header");
    cmp_range(base, 42, 50, "R4", "udp header");
    if (eff > 0) cmp_range(base, 50, 50 + eff, "R5", "payload");
    if (eff < 18) cmp_range(base, 50 + eff, 50 + plen, "R6", "zero padding");
    cmp_range(base, 50 + plen, en_n, "R7", "frame check bytes");
    check(crc_over(8, got, 1'b1, base) == 32'hDEBB20E3, "R7", "crc residue",
          int'(crc_over(8, got, 1'b1, base)), int'(32'hDEBB20E3));
  endtask

  initial begin
    rst_n     = 1'b0;
    cfg_bcast = 1'b0;
    pl_len    = 11'd0;
    repeat (3) @(negedge clk);
    go = 1'b1;  // offered during reset: must be ignored
    @(negedge clk);
    check(tx_en === 1'b0, "R10", "tx_en in reset", int'(tx_en), 0);
    check(pl_ready === 1'b0, "R10", "pl_ready in reset", int'(pl_ready), 0);
    go = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(tx_en === 1'b0, "R10", "tx_en idle after reset", int'(tx_en), 0);
    check(pl_ready === 1'b0, "R10", "pl_ready idle after reset", int'(pl_ready), 0);
    check(ncap == 0, "R10", "bytes sent before any payload", ncap, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_frame(int'(VEC[v][19:9]), VEC[v][8], VEC[v][7:0], "R6");
    end

    // clamp of oversized length, then the maximum itself
    run_frame(1500, 1'b0, 8'h77, "R8");
    run_frame(1472, 1'b1, 8'h88, "R8");
    // one more short frame right behind
    run_frame(1, 1'b0, 8'h99, "R6");

    if (!hung) check(min_gap >= 12, "R9", "minimum idle gap", min_gap, 12);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule